// File: doc/BRIEF.md
# Host Byte-Lane Steering and Masking Unit

This block joins a byte-addressed host bus to a 32-bit SDRAM data path. For every host access it works out which of the four 8-bit lanes of the SDRAM word are touched. It then drives one active-low byte mask per lane, places the host's write data on those lanes, and hands read data back to the host in the layout the host expects. The word address, write data and masks toward the SDRAM are registered once. The read return path is combinational, so data arriving from the SDRAM reaches the host in the same cycle.

The parameter `ALIGN_LOW` selects one of two data layouts at build time. With it set, narrow data always travels on the low bits of the host bus, which suits a narrow host that has to reach the whole memory. With it cleared, narrow data stays on its natural lanes, chosen by the low address bits. Command sequencing and refresh are handled elsewhere.

Top module: `host_lane_steer`

## Requirements
- R1: While `rst_n` is low, `sd_dqm_n` is 4'b1111, and `sd_wdata` and `sd_addr` are zero.
- R2: Size code 0 is a 32-bit access. Code 3 is treated the same way. After the next rising clock edge, all four `sd_dqm_n` bits are 0.
- R3: Size code 1 is an 8-bit access. After the next edge, exactly one mask bit is low: bit `host_addr[1:0]`. Mask bit i guards lane i, and lane 0 is data bits [7:0].
- R4: Size code 2 is a 16-bit access. After the next edge, `sd_dqm_n` is 4'b0011 when `host_addr[1]` is 1 and 4'b1100 when it is 0.
- R5: One clock edge after the host presents an access, `sd_addr` equals that access's `host_addr[22:2]`.
- R6: With `ALIGN_LOW`=1, `sd_wdata` one edge later is as follows:
  - for an 8-bit access, `host_wdata[7:0]` copied onto all four lanes;
  - for a 16-bit access, `host_wdata[15:0]` copied onto both halves;
  - for a 32-bit access, `host_wdata` unchanged.
- R7: With `ALIGN_LOW`=0, `sd_wdata` one edge later equals `host_wdata` unchanged, whatever the size.
- R8: With `ALIGN_LOW`=1, `host_rdata` in the same cycle is as follows, with all bits above the returned data zero:
  - for an 8-bit access, lane `host_addr[1:0]` of `sd_rdata`, placed on bits [7:0];
  - for a 16-bit access, half `host_addr[1]` of `sd_rdata`, placed on bits [15:0];
  - for a 32-bit access, `sd_rdata` in full.
- R9: With `ALIGN_LOW`=0, `host_rdata` in the same cycle is `sd_rdata`, with the lanes the access does not touch (per R2 to R4) forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 23 | Host byte address |
| host_size | input | 2 | Access size: 0 = 32-bit, 1 = 8-bit, 2 = 16-bit |
| host_wdata | input | 32 | Write data from the host |
| host_rdata | output | 32 | Read data returned to the host |
| sd_addr | output | 21 | Registered word address toward the SDRAM |
| sd_wdata | output | 32 | Registered lane-steered write data |
| sd_dqm_n | output | 4 | Registered active-low byte masks, bit i for lane i |
| sd_rdata | input | 32 | Read data from the SDRAM |

## Verification
The embedded properties check four things on every cycle:
- the number of enabled lanes per size;
- the full mask for word accesses;
- the word address carried one cycle later;
- in the selected layout, the zero upper bits of aligned narrow reads, or the single lane chosen by the address for natural byte writes.

Only the bench scenarios can show the exact data values, which depend on both layouts side by side. These are the replication of narrow write data, which lane a read is taken from, and the zeroing of untouched lanes in natural mode. The bench also covers every size code against every low address pattern.

// File: rtl/host_lane_steer.sv
module host_lane_steer #(
  parameter int ADDR_W    = 23,
  parameter int DATA_W    = 32,
  parameter bit ALIGN_LOW = 1'b1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [ADDR_W-1:0]                     host_addr,
  input  logic [1:0]                            host_size,
  input  logic [DATA_W-1:0]                     host_wdata,
  output logic [DATA_W-1:0]                     host_rdata,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]    sd_addr,
  output logic [DATA_W-1:0]                     sd_wdata,
  output logic [DATA_W/8-1:0]                   sd_dqm_n,
  input  logic [DATA_W-1:0]                     sd_rdata
);
  localparam int LANES = DATA_W / 8;
  localparam int SEL_W = $clog2(LANES);
  localparam int WORD_W = ADDR_W - SEL_W;
  localparam logic [1:0] SZ_BYTE = 2'd1;
  localparam logic [1:0] SZ_HALF = 2'd2;

  logic             is_byte, is_half;
  logic [SEL_W-1:0] byte_idx;
  logic [SEL_W-2:0] half_idx;
  logic [LANES-1:0] lane_en;
  logic [DATA_W-1:0] wdata_steer;

  assign is_byte  = (host_size == SZ_BYTE);
  assign is_half  = (host_size == SZ_HALF);
  assign byte_idx = host_addr[SEL_W-1:0];
  assign half_idx = host_addr[SEL_W-1:1];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (is_byte)      lane_en[i] = (i == int'(byte_idx));
      else if (is_half) lane_en[i] = ((i / 2) == int'(half_idx));
      else              lane_en[i] = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (ALIGN_LOW && is_byte)      wdata_steer[8*i +: 8] = host_wdata[7:0];
      else if (ALIGN_LOW && is_half) wdata_steer[8*i +: 8] = host_wdata[8*(i%2) +: 8];
      else                           wdata_steer[8*i +: 8] = host_wdata[8*i +: 8];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (ALIGN_LOW) begin
      if (is_byte) begin
        host_rdata[7:0] = sd_rdata[8*byte_idx +: 8];
      end else if (is_half) begin
        host_rdata[15:0] = sd_rdata[16*half_idx +: 16];
      end else begin
        host_rdata = sd_rdata;
      end
    end else begin
      for (int i = 0; i < LANES; i++)
        host_rdata[8*i +: 8] = sd_rdata[8*i +: 8] & {8{lane_en[i]}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_addr  <= '0;
      sd_wdata <= '0;
      sd_dqm_n <= '1;
    end else begin
      sd_addr  <= host_addr[ADDR_W-1:SEL_W];
      sd_wdata <= wdata_steer;
      sd_dqm_n <= ~lane_en;
    end
  end

  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_size == 2'd0 || host_size == 2'd3) |=> (sd_dqm_n == '0)); // R2
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_size == SZ_BYTE) |=> ($countones(~sd_dqm_n) == 1)); // R3
  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_size == SZ_HALF) |=> ($countones(~sd_dqm_n) == 2)); // R4
  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sd_addr == $past(host_addr[ADDR_W-1:SEL_W]))); // R5

  generate
    if (ALIGN_LOW) begin : g_align_chk
      AST_BYTE_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_size == SZ_BYTE) |-> (host_rdata[DATA_W-1:8] == '0)); // R8
      AST_HALF_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_size == SZ_HALF) |-> (host_rdata[DATA_W-1:16] == '0)); // R8
    end else begin : g_natural_chk
      AST_BYTE_LANE_BY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_size == SZ_BYTE) |=> (~sd_dqm_n == (LANES'(1) << $past(host_addr[SEL_W-1:0])))); // R3
    end
  endgenerate
endmodule

// File: tb/sim_host_lane_steer.sv
module sim_host_lane_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] sd_rdata = '0;
  logic [31:0] rd_a, rd_n, wd_a, wd_n;
  logic [20:0] ad_a, ad_n;
  logic [3:0]  dq_a, dq_n;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  host_lane_steer #(.ALIGN_LOW(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_size(host_size),
    .host_wdata(host_wdata), .host_rdata(rd_a), .sd_addr(ad_a),
    .sd_wdata(wd_a), .sd_dqm_n(dq_a), .sd_rdata(sd_rdata));

  host_lane_steer #(.ALIGN_LOW(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_size(host_size),
    .host_wdata(host_wdata), .host_rdata(rd_n), .sd_addr(ad_n),
    .sd_wdata(wd_n), .sd_dqm_n(dq_n), .sd_rdata(sd_rdata));

  function automatic logic [3:0] m_dqm(logic [1:0] sz, logic [22:0] a);
    case (sz)
      2'd1: return ~(4'b0001 << a[1:0]);
      2'd2: return a[1] ? 4'b0011 : 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] m_wdata(bit al, logic [1:0] sz, logic [31:0] w);
    if (!al) return w;
    if (sz == 2'd1) return {4{w[7:0]}};
    if (sz == 2'd2) return {2{w[15:0]}};
    return w;
  endfunction

  function automatic logic [31:0] m_rdata(bit al, logic [1:0] sz, logic [22:0] a, logic [31:0] r);
    logic [3:0]  en;
    logic [31:0] mask;
    if (sz == 2'd0 || sz == 2'd3) return r;
    if (al) begin
      if (sz == 2'd1) return (r >> (8 * a[1:0])) & 32'h0000_00FF;
      return (r >> (16 * a[1])) & 32'h0000_FFFF;
    end
    en = ~m_dqm(sz, a);
    mask = {{8{en[3]}}, {8{en[2]}}, {8{en[1]}}, {8{en[0]}}};
    return r & mask;
  endfunction

  function automatic string dqm_tag(logic [1:0] sz);
    if (sz == 2'd1) return "R3";
    if (sz == 2'd2) return "R4";
    return "R2";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [22:0] p_addr;
  logic [1:0]  p_size;
  logic [31:0] p_wdata;
  bit          have_prev = 0;

  task automatic step(logic [22:0] a, logic [1:0] sz, logic [31:0] w, logic [31:0] r);
    @(negedge clk);
    if (have_prev) begin
      check("R5 addr aligned",   {11'd0, ad_a}, {11'd0, p_addr[22:2]});
      check("R5 addr natural",   {11'd0, ad_n}, {11'd0, p_addr[22:2]});
      check({dqm_tag(p_size), " dqm aligned"}, {28'd0, dq_a}, {28'd0, m_dqm(p_size, p_addr)});
      check({dqm_tag(p_size), " dqm natural"}, {28'd0, dq_n}, {28'd0, m_dqm(p_size, p_addr)});
      check("R6 wdata aligned",  wd_a, m_wdata(1'b1, p_size, p_wdata));
      check("R7 wdata natural",  wd_n, m_wdata(1'b0, p_size, p_wdata));
    end
    host_addr = a; host_size = sz; host_wdata = w; sd_rdata = r;
    p_addr = a; p_size = sz; p_wdata = w; have_prev = 1;
    #1;
    check("R8 rdata aligned", rd_a, m_rdata(1'b1, sz, a, r));
    check("R9 rdata natural", rd_n, m_rdata(1'b0, sz, a, r));
  endtask

  initial begin
    host_addr = 23'h7F_FFFF; host_size = 2'd1; host_wdata = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset dqm aligned",   {28'd0, dq_a}, 32'h0000_000F);
    check("R1 reset dqm natural",   {28'd0, dq_n}, 32'h0000_000F);
    check("R1 reset wdata aligned", wd_a, 32'd0);
    check("R1 reset addr natural",  {11'd0, ad_n}, 32'd0);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++)
      for (int lo = 0; lo < 4; lo++)
        step({21'h15_5A5A, 2'(lo)}, 2'(s), 32'hA1B2_C3D4, 32'h1122_3344);
    step(23'h7F_FFFF, 2'd1, 32'hFFFF_FF5A, 32'h8000_0001);
    step(23'h00_0000, 2'd2, 32'h0000_0000, 32'hFFFF_FFFF);
    for (int k = 0; k < 300; k++)
      step(23'($urandom), 2'($urandom), $urandom, $urandom);
    step(23'h0, 2'd0, 32'h0, 32'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule